// File: doc/BRIEF.md
# DDR Bank Timing Checker

This block watches a stream of decoded DDR SDRAM commands, one command per clock, and judges each one against the device's spacing rules. It tracks which of its banks hold an open row. For every rule that spans commands it keeps a timer: per bank for row-level rules, and shared for column and mode-set rules. All minimum intervals are parameters counted in clock cycles.

For each cycle it raises `cmdLegal` when the present command breaks no rule. It also drives a one-hot `violation` vector that names the highest-priority rule broken. A command judged illegal is still applied to the tracked state, so checking carries on sensibly after the first mistake.

A gap of g cycles means the second command is presented g clock cycles after the first. Every interval rule below is met when g is at least the stated minimum.

Top module: `ddrchk_bank_timing`

## Requirements
- R1: After reset every bank is closed and every timer has expired. A no-operation is then legal with `violation` zero, and an activate to any bank is legal.
- R2: Command codes on `cmdCode` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 mode set, and 7 also no-op. A no-op is always legal. `violation` has at most one bit set: the lowest-numbered rule broken, in this order: bit0 mode-set gap, bit1 banks-not-quiet, bit2 bank-state, bit3 T_RCD, bit4 write-auto-precharge burst, bit5 write-to-read, bit6 T_CCD, bit7 T_RAS, bit8 T_RC, bit9 T_RP, bit10 write-auto-precharge recovery, bit11 T_RRD. `cmdLegal` is 1 exactly when `violation` is zero.
- R3: A read or write to an open bank less than T_RCD after that bank's activate sets bit3.
- R4: A precharge less than T_RAS after the activate of an open bank it closes sets bit7. When `cmdAutoPre` is high, a precharge closes every open bank and `cmdBank` is ignored.
- R5: An activate to a bank less than T_RC after its previous activate sets bit8. An activate less than T_RP after a precharge closed that bank sets bit9.
- R6: Two activates less than T_RRD apart set bit11 on the second.
- R7: A write with `cmdAutoPre` high closes its bank. An activate to that bank less than BURST_CYC+T_WR+T_RP after the write sets bit10.
- R8: After a write with `cmdAutoPre` high, any read or write to any bank less than BURST_CYC later sets bit4.
- R9: A read less than BURST_CYC+T_WTR after any write sets bit5. Any read or write less than T_CCD after the previous read or write sets bit6.
- R10: A read or write to a closed bank, or an activate to an open bank, sets bit2.
- R11: Auto refresh or mode set is legal only when every bank is closed and its T_RP, read-auto-precharge and write-auto-precharge windows have run out; otherwise bit1 is set.
- R12: Any command other than a no-op less than T_MRD after a mode set sets bit0.
- R13: A read with `cmdAutoPre` high closes its bank. An activate to that bank less than BURST_CYC+T_RP after the read sets bit9.
- R14: Illegal commands still update state. For example, an activate flagged for T_RRD still opens its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCode | input | 3 | Decoded command code (see R2) |
| cmdBank | input | log2(NUM_BANKS) = 2 | Target bank |
| cmdAutoPre | input | 1 | Auto-precharge on read/write; all-banks on precharge |
| cmdLegal | output | 1 | Present command breaks no rule |
| violation | output | 12 | One-hot code of the highest-priority broken rule |

## Verification
Several windows can close in the same cycle. The sharpest cases are T_RC and T_RP after a precharge placed exactly T_RAS after the activate, and the write-auto-precharge burst window overlapping the write-to-read and column-gap rules. The bench provokes these by sweeping the gap of the second command across every value up to one past the longest window involved. It computes the expected vector from the gap arithmetic and the priority order, so a wrong winner or a window that is off by one shows up as a mismatched bit.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  localparam int NUM_VIOL = 12;

  // Violation bit positions; a lower index wins when several rules break.
  localparam int V_MRD   = 0;
  localparam int V_BUSY  = 1;
  localparam int V_STATE = 2;
  localparam int V_RCD   = 3;
  localparam int V_BURST = 4;
  localparam int V_WTR   = 5;
  localparam int V_CCD   = 6;
  localparam int V_RAS   = 7;
  localparam int V_RC    = 8;
  localparam int V_RP    = 9;
  localparam int V_DAL   = 10;
  localparam int V_RRD   = 11;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmdCode_e;

  // Strobes from the command control to the timer datapath.
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic mrs;
    logic autoPre;
  } ctrlStb_t;

endpackage

// File: rtl/ddrchk_downcnt.sv
module ddrchk_downcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  output logic             done
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remain <= '0;
    else if (load)            remain <= loadVal;
    else if (remain != '0)    remain <= remain - CNT_W'(1);
  end

  assign done = (remain == '0);

endmodule

// File: rtl/ddrchk_bank_timers.sv
module ddrchk_bank_timers
  import ddrchk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_CCD     = 1,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [BANK_W-1:0]    bankSel,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] rcdDone,
  output logic [NUM_BANKS-1:0] rasDone,
  output logic [NUM_BANKS-1:0] rcDone,
  output logic [NUM_BANKS-1:0] rpDone,
  output logic [NUM_BANKS-1:0] dalDone,
  output logic                 rrdDone,
  output logic                 ccdDone,
  output logic                 wtrDone,
  output logic                 burstDone,
  output logic                 mrdDone
);

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DAL_CYC  = BURST_CYC + T_WR + T_RP;
  localparam int RDAP_CYC = BURST_CYC + T_RP;
  localparam int WTR_CYC  = BURST_CYC + T_WTR;
  localparam int MAX_LEN  = maxOf(maxOf(maxOf(T_RCD, T_RAS), maxOf(T_RC, DAL_CYC)),
                                  maxOf(maxOf(RDAP_CYC, WTR_CYC),
                                        maxOf(maxOf(T_RRD, T_CCD), maxOf(T_MRD, BURST_CYC))));
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  // Per-bank row state and windows
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, closeNow, apHere, openQ, rpLoad;
    logic [CNT_W-1:0] rpVal;

    assign hit      = (bankSel == BANK_W'(b));
    assign closeNow = stb.pre && openQ && (stb.preAll || hit);
    assign apHere   = (stb.rd || stb.wr) && stb.autoPre && hit;
    assign rpLoad   = closeNow || (stb.rd && stb.autoPre && hit);
    assign rpVal    = closeNow ? CNT_W'(T_RP - 1) : CNT_W'(RDAP_CYC - 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  openQ <= 1'b0;
      else if (stb.act && hit)    openQ <= 1'b1;
      else if (closeNow || apHere) openQ <= 1'b0;
    end
    assign bankOpen[b] = openQ;

    ddrchk_downcnt #(.CNT_W(CNT_W)) rcdCnt_i (
      .clk(clk), .rstN(rstN), .load(stb.act && hit),
      .loadVal(CNT_W'(T_RCD - 1)), .done(rcdDone[b]));
    ddrchk_downcnt #(.CNT_W(CNT_W)) rasCnt_i (
      .clk(clk), .rstN(rstN), .load(stb.act && hit),
      .loadVal(CNT_W'(T_RAS - 1)), .done(rasDone[b]));
    ddrchk_downcnt #(.CNT_W(CNT_W)) rcCnt_i (
      .clk(clk), .rstN(rstN), .load(stb.act && hit),
      .loadVal(CNT_W'(T_RC - 1)), .done(rcDone[b]));
    ddrchk_downcnt #(.CNT_W(CNT_W)) rpCnt_i (
      .clk(clk), .rstN(rstN), .load(rpLoad),
      .loadVal(rpVal), .done(rpDone[b]));
    ddrchk_downcnt #(.CNT_W(CNT_W)) dalCnt_i (
      .clk(clk), .rstN(rstN), .load(stb.wr && stb.autoPre && hit),
      .loadVal(CNT_W'(DAL_CYC - 1)), .done(dalDone[b]));
  end

  // Windows shared by all banks
  ddrchk_downcnt #(.CNT_W(CNT_W)) rrdCnt_i (
    .clk(clk), .rstN(rstN), .load(stb.act),
    .loadVal(CNT_W'(T_RRD - 1)), .done(rrdDone));
  ddrchk_downcnt #(.CNT_W(CNT_W)) ccdCnt_i (
    .clk(clk), .rstN(rstN), .load(stb.rd || stb.wr),
    .loadVal(CNT_W'(T_CCD - 1)), .done(ccdDone));
  ddrchk_downcnt #(.CNT_W(CNT_W)) wtrCnt_i (
    .clk(clk), .rstN(rstN), .load(stb.wr),
    .loadVal(CNT_W'(WTR_CYC - 1)), .done(wtrDone));
  ddrchk_downcnt #(.CNT_W(CNT_W)) burstCnt_i (
    .clk(clk), .rstN(rstN), .load(stb.wr && stb.autoPre),
    .loadVal(CNT_W'(BURST_CYC - 1)), .done(burstDone));
  ddrchk_downcnt #(.CNT_W(CNT_W)) mrdCnt_i (
    .clk(clk), .rstN(rstN), .load(stb.mrs),
    .loadVal(CNT_W'(T_MRD - 1)), .done(mrdDone));

endmodule

// File: rtl/ddrchk_cmd_ctrl.sv
module ddrchk_cmd_ctrl
  import ddrchk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [2:0]           cmdCode,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 cmdAutoPre,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] rcdDone,
  input  logic [NUM_BANKS-1:0] rasDone,
  input  logic [NUM_BANKS-1:0] rcDone,
  input  logic [NUM_BANKS-1:0] rpDone,
  input  logic [NUM_BANKS-1:0] dalDone,
  input  logic                 rrdDone,
  input  logic                 ccdDone,
  input  logic                 wtrDone,
  input  logic                 burstDone,
  input  logic                 mrdDone,
  output ctrlStb_t             stb,
  output logic                 cmdLegal,
  output logic [NUM_VIOL-1:0]  violation
);

  logic isAct, isRd, isWr, isPre, isRef, isMrs, isCol, isCmd;
  logic quiet, selOpen;
  logic [NUM_BANKS-1:0] preMask;
  logic [NUM_VIOL-1:0]  raw;
  logic found;

  assign isAct = (cmdCode == CMD_ACT);
  assign isRd  = (cmdCode == CMD_RD);
  assign isWr  = (cmdCode == CMD_WR);
  assign isPre = (cmdCode == CMD_PRE);
  assign isRef = (cmdCode == CMD_REF);
  assign isMrs = (cmdCode == CMD_MRS);
  assign isCol = isRd || isWr;
  assign isCmd = isAct || isCol || isPre || isRef || isMrs;

  assign stb.act     = isAct;
  assign stb.rd      = isRd;
  assign stb.wr      = isWr;
  assign stb.pre     = isPre;
  assign stb.preAll  = isPre && cmdAutoPre;
  assign stb.mrs     = isMrs;
  assign stb.autoPre = cmdAutoPre;

  assign selOpen = bankOpen[cmdBank];
  assign quiet   = &(~bankOpen & rpDone & dalDone);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      preMask[b] = cmdAutoPre || (cmdBank == BANK_W'(b));
  end

  always_comb begin
    raw          = '0;
    raw[V_MRD]   = isCmd && !mrdDone;
    raw[V_BUSY]  = (isRef || isMrs) && !quiet;
    raw[V_STATE] = (isCol && !selOpen) || (isAct && selOpen);
    raw[V_RCD]   = isCol && selOpen && !rcdDone[cmdBank];
    raw[V_BURST] = isCol && !burstDone;
    raw[V_WTR]   = isRd && !wtrDone;
    raw[V_CCD]   = isCol && !ccdDone;
    raw[V_RAS]   = isPre && |(preMask & bankOpen & ~rasDone);
    raw[V_RC]    = isAct && !rcDone[cmdBank];
    raw[V_RP]    = isAct && !rpDone[cmdBank];
    raw[V_DAL]   = isAct && !dalDone[cmdBank];
    raw[V_RRD]   = isAct && !rrdDone;
  end

  // Keep only the highest-priority (lowest-index) rule.
  always_comb begin
    violation = '0;
    found     = 1'b0;
    for (int i = 0; i < NUM_VIOL; i++) begin
      if (raw[i] && !found) begin
        violation[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign cmdLegal = ~|raw;

endmodule

// File: rtl/ddrchk_bank_timing.sv
module ddrchk_bank_timing
  import ddrchk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int T_CCD     = 1,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cmdCode,
  input  logic [BANK_W-1:0]   cmdBank,
  input  logic                cmdAutoPre,
  output logic                cmdLegal,
  output logic [NUM_VIOL-1:0] violation
);

  ctrlStb_t stb;
  logic [NUM_BANKS-1:0] bankOpen, rcdDone, rasDone, rcDone, rpDone, dalDone;
  logic rrdDone, ccdDone, wtrDone, burstDone, mrdDone;

  ddrchk_cmd_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) ctrl_i (
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAutoPre(cmdAutoPre),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .rasDone(rasDone),
    .rcDone(rcDone), .rpDone(rpDone), .dalDone(dalDone),
    .rrdDone(rrdDone), .ccdDone(ccdDone), .wtrDone(wtrDone),
    .burstDone(burstDone), .mrdDone(mrdDone),
    .stb(stb), .cmdLegal(cmdLegal), .violation(violation));

  ddrchk_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RC(T_RC), .T_RP(T_RP), .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR),
    .T_CCD(T_CCD), .T_MRD(T_MRD), .BURST_CYC(BURST_CYC)
  ) timers_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bankSel(cmdBank),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .rasDone(rasDone),
    .rcDone(rcDone), .rpDone(rpDone), .dalDone(dalDone),
    .rrdDone(rrdDone), .ccdDone(ccdDone), .wtrDone(wtrDone),
    .burstDone(burstDone), .mrdDone(mrdDone));

endmodule

// File: rtl/ddrchk_sva.sv
module ddrchk_sva
  import ddrchk_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int T_RCD  = 3,
  parameter int T_RRD  = 2,
  parameter int T_MRD  = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          cmdCode,
  input logic [BANK_W-1:0]   cmdBank,
  input logic                cmdLegal,
  input logic [NUM_VIOL-1:0] violation
);

  logic isNop;
  assign isNop = (cmdCode == CMD_NOP) || (cmdCode == CMD_RSV);

  // R2
  viol_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(violation));

  // R2
  nop_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    isNop |-> (cmdLegal && violation == '0));

  // R2
  legal_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLegal == (violation == '0));

  // R12
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((T_MRD >= 2) && $past(rstN) && $past(cmdCode) == CMD_MRS && !isNop)
      |-> violation[V_MRD]);

  // R6
  rrd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((T_RRD >= 2) && $past(rstN) && $past(cmdCode) == CMD_ACT &&
     cmdCode == CMD_ACT && cmdBank != $past(cmdBank)) |-> !cmdLegal);

  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((T_RCD >= 2) && $past(rstN) && $past(cmdCode) == CMD_ACT &&
     (cmdCode == CMD_RD || cmdCode == CMD_WR) && cmdBank == $past(cmdBank))
      |-> violation[V_RCD]);

  // R10
  act_twice_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmdCode) == CMD_ACT && cmdCode == CMD_ACT &&
     cmdBank == $past(cmdBank)) |-> violation[V_STATE]);

  // R11
  ref_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmdCode) == CMD_ACT && cmdCode == CMD_REF)
      |-> violation[V_BUSY]);

endmodule

bind ddrchk_bank_timing ddrchk_sva #(
  .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_MRD(T_MRD)
) sva_i (
  .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdBank(cmdBank),
  .cmdLegal(cmdLegal), .violation(violation));

// File: tb/ddrchk_bank_timing_tb_top.sv
module ddrchk_bank_timing_tb_top;

  localparam int T_RCD = 3, T_RAS = 6, T_RC = 9, T_RP = 3, T_RRD = 2;
  localparam int T_WR = 2, T_WTR = 1, T_CCD = 2, T_MRD = 2, BC = 2;
  localparam int DAL = BC + T_WR + T_RP;
  localparam int RDAP = BC + T_RP;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_NOP7 = 3'd7;
  localparam int B_MRD = 0, B_BUSY = 1, B_STATE = 2, B_RCD = 3, B_BURST = 4,
                 B_WTR = 5, B_CCD = 6, B_RAS = 7, B_RC = 8, B_RP = 9,
                 B_DAL = 10, B_RRD = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic cmdAutoPre = 1'b0;
  logic cmdLegal;
  logic [11:0] violation;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ddrchk_bank_timing #(
    .NUM_BANKS(4), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
    .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR), .T_CCD(T_CCD),
    .T_MRD(T_MRD), .BURST_CYC(BC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAutoPre(cmdAutoPre), .cmdLegal(cmdLegal), .violation(violation));

  function automatic logic [11:0] vb(input int i);
    return 12'(1) << i;
  endfunction

  task automatic drive(input logic [2:0] c, input int b, input logic ap);
    @(negedge clk);
    cmdCode = c; cmdBank = 2'(b); cmdAutoPre = ap;
    #2;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) drive(C_NOP, 0, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    cmdCode = C_NOP; cmdBank = 2'd0; cmdAutoPre = 1'b0; rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic check(input string req, input logic [11:0] expViol);
    logic expLegal;
    expLegal = (expViol == 12'd0);
    checks++;
    if (cmdLegal !== expLegal || violation !== expViol) begin
      errors++;
      $display("FAIL %s: legal=%0b viol=%03h expected legal=%0b viol=%03h",
               req, cmdLegal, violation, expLegal, expViol);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset();
    drive(C_NOP, 0, 1'b0);  check("R1", 12'd0);
    drive(C_NOP7, 2, 1'b1); check("R2", 12'd0);
    drive(C_ACT, 3, 1'b0);  check("R1", 12'd0);
    // R1: reset closes a bank that was open
    nops(T_RC);
    doReset();
    drive(C_RD, 3, 1'b0);   check("R1", vb(B_STATE));

    // R3: activate to column gap
    for (int g = 1; g <= T_RCD + 1; g++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(g - 1);
      drive(C_RD, 0, 1'b0);
      check("R3", (g < T_RCD) ? vb(B_RCD) : 12'd0);
    end

    // R4: activate to precharge gap
    for (int g = 1; g <= T_RAS + 1; g++) begin
      doReset();
      drive(C_ACT, 1, 1'b0); nops(g - 1);
      drive(C_PRE, 1, 1'b0);
      check("R4", (g < T_RAS) ? vb(B_RAS) : 12'd0);
    end
    // R4: precharge-all too early for the younger bank
    doReset();
    drive(C_ACT, 0, 1'b0); nops(T_RRD - 1);
    drive(C_ACT, 2, 1'b0); nops(T_RAS - T_RRD - 1);
    drive(C_PRE, 1, 1'b1);
    check("R4", vb(B_RAS));

    // R4 / R11: precharge-all ignores bank field, then refresh gap
    for (int h = 1; h <= T_RP + 1; h++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RRD - 1);
      drive(C_ACT, 2, 1'b0); nops(T_RAS - 1);
      drive(C_PRE, 1, 1'b1); check("R4", 12'd0);
      nops(h - 1);
      drive(C_REF, 0, 1'b0);
      check("R11", (h < T_RP) ? vb(B_BUSY) : 12'd0);
    end

    // R5: T_RC and T_RP coincide when precharge sits at T_RAS
    for (int g = T_RAS + 1; g <= T_RC + 1; g++) begin
      doReset();
      drive(C_ACT, 2, 1'b0); nops(T_RAS - 1);
      drive(C_PRE, 2, 1'b0); nops(g - T_RAS - 1);
      drive(C_ACT, 2, 1'b0);
      check("R5", (g < T_RC) ? vb(B_RC) :
                  ((g - T_RAS < T_RP) ? vb(B_RP) : 12'd0));
    end
    // R5: T_RP alone
    for (int h = 1; h <= T_RP + 1; h++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RC - 2);
      drive(C_PRE, 0, 1'b0); nops(h - 1);
      drive(C_ACT, 0, 1'b0);
      check("R5", (h < T_RP) ? vb(B_RP) : 12'd0);
    end

    // R6: activate to activate, different banks
    for (int g = 1; g <= T_RRD + 1; g++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(g - 1);
      drive(C_ACT, 1, 1'b0);
      check("R6", (g < T_RRD) ? vb(B_RRD) : 12'd0);
    end

    // R7: write with auto-precharge to next activate
    for (int h = 1; h <= DAL + 1; h++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RC - 1);
      drive(C_WR, 0, 1'b1);  nops(h - 1);
      drive(C_ACT, 0, 1'b0);
      check("R7", (h < DAL) ? vb(B_DAL) : 12'd0);
    end

    // R8 / R9: column commands behind a write with auto-precharge
    for (int g = 1; g <= BC + T_WTR + 1; g++) begin
      for (int isRead = 0; isRead < 2; isRead++) begin
        logic [11:0] e;
        doReset();
        drive(C_ACT, 0, 1'b0); nops(T_RRD - 1);
        drive(C_ACT, 1, 1'b0); nops(T_RCD - 1);
        drive(C_WR, 0, 1'b1);  nops(g - 1);
        drive(isRead ? C_RD : C_WR, 1, 1'b0);
        if (g < BC)                          e = vb(B_BURST);
        else if (isRead && g < BC + T_WTR)   e = vb(B_WTR);
        else if (g < T_CCD)                  e = vb(B_CCD);
        else                                 e = 12'd0;
        check("R8", e);
      end
    end

    // R9: write to read turnaround
    for (int g = 1; g <= BC + T_WTR + 1; g++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RCD - 1);
      drive(C_WR, 0, 1'b0);  nops(g - 1);
      drive(C_RD, 0, 1'b0);
      check("R9", (g < BC + T_WTR) ? vb(B_WTR) :
                  ((g < T_CCD) ? vb(B_CCD) : 12'd0));
    end
    // R9: column spacing
    for (int g = 1; g <= T_CCD + 1; g++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RCD - 1);
      drive(C_RD, 0, 1'b0);  nops(g - 1);
      drive(C_RD, 0, 1'b0);
      check("R9", (g < T_CCD) ? vb(B_CCD) : 12'd0);
    end

    // R10: bank state
    doReset();
    drive(C_WR, 2, 1'b0);  check("R10", vb(B_STATE));
    drive(C_ACT, 0, 1'b0); nops(T_RC - 1);
    drive(C_ACT, 0, 1'b0); check("R10", vb(B_STATE));

    // R11: refresh and mode set with a bank open
    doReset();
    drive(C_ACT, 0, 1'b0); nops(T_RC - 1);
    drive(C_REF, 0, 1'b0); check("R11", vb(B_BUSY));
    drive(C_MRS, 0, 1'b0); check("R11", vb(B_BUSY));
    // R11: refresh during write auto-precharge recovery
    for (int h = 1; h <= DAL + 1; h++) begin
      doReset();
      drive(C_ACT, 0, 1'b0); nops(T_RCD - 1);
      drive(C_WR, 0, 1'b1);  nops(h - 1);
      drive(C_REF, 0, 1'b0);
      check("R11", (h < DAL) ? vb(B_BUSY) : 12'd0);
    end

    // R12: mode set gap
    doReset();
    drive(C_MRS, 0, 1'b0); check("R12", 12'd0);
    drive(C_NOP, 0, 1'b0); check("R12", 12'd0);
    for (int g = 1; g <= T_MRD + 1; g++) begin
      doReset();
      drive(C_MRS, 0, 1'b0); nops(g - 1);
      drive(C_ACT, 0, 1'b0);
      check("R12", (g < T_MRD) ? vb(B_MRD) : 12'd0);
    end

    // R13: read with auto-precharge
    for (int h = 1; h <= RDAP + 1; h++) begin
      doReset();
      drive(C_ACT, 1, 1'b0); nops(T_RC - 1);
      drive(C_RD, 1, 1'b1);  nops(h - 1);
      drive(C_ACT, 1, 1'b0);
      check("R13", (h < RDAP) ? vb(B_RP) : 12'd0);
    end
    doReset();
    drive(C_ACT, 1, 1'b0); nops(T_RCD - 1);
    drive(C_RD, 1, 1'b1);  nops(T_CCD - 1);
    drive(C_RD, 1, 1'b0);  check("R13", vb(B_STATE));

    // R14: illegal activate still opens its bank
    doReset();
    drive(C_ACT, 0, 1'b0);
    drive(C_ACT, 1, 1'b0); check("R14", vb(B_RRD));
    nops(T_RCD - 1);
    drive(C_RD, 1, 1'b0);  check("R14", 12'd0);

    drive(C_NOP, 0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule